// File: doc/BRIEF.md
# Temperature limit status and alert logic

This block is the register-side status logic of a four-channel temperature monitor. Channel 0 is the on-die sensor and channels 1 to 3 are remote sensors. A strobe marks each finished conversion, and at that strobe every channel's signed 8-bit reading is compared against its own programmable high limit and low limit. Channels that are out of limit set flags in two status registers: one register holds the high flags and the other holds the low flags. Reading a status register clears it. Two summary bits in a general status register report whether any high flag or any low flag is set.

An active-low alert output is driven from the flags. Each channel has its own counter of back-to-back out-of-limit conversions. A channel drives the alert only when its counter has passed a programmed threshold and it also has a flag set. In comparator mode the flags follow the latest comparison directly, and a read does not clear them. A simple synchronous register port with address, write strobe, read strobe and registered read data gives access to the limits, the configuration and the status.

Top module: `thermal_limit_status`

## Requirements
- R1: After reset, the registers at 35h, 36h and 02h read 00h and `alert_n` is 1.
- R2: The high status register at 35h uses bit 0 for the on-die channel and bits 1 to 3 for remote channels 1 to 3. Bits 7 to 4 read 0. A channel's bit is set at the conversion where its reading is greater than its high limit, compared as signed values. A reading equal to the limit does not set the bit.
- R3: The low status register at 36h uses the same bit layout as R2. A channel's bit is set at the conversion where its reading is less than its low limit, compared as signed values. A reading equal to the limit does not set the bit.
- R4: In latched mode, a set flag stays set through later in-limit conversions. A read of its status register returns the value before the clear and then clears every bit of that register.
- R5: In register 02h, bit 1 is 1 whenever any high flag is set and bit 0 is 1 whenever any low flag is set. Both bits go to 0 once their status register has been cleared. Reading 02h clears nothing.
- R6: If a clearing read and a new out-of-limit conversion fall in the same cycle, the read returns the old value and the new flag stays set.
- R7: When bit 0 of the configuration register at 03h is 1 (comparator mode), each flag takes the result of the latest conversion and a read does not clear it.
- R8: Bits 3:1 of register 03h hold a count N. A channel drives the alert only after N+1 back-to-back out-of-limit conversions (above the high limit or below the low limit), and only while it has a flag set. One in-limit conversion resets that channel's run. `alert_n` is 0 exactly when some channel meets both conditions.
- R9: For channel c, the high limit is at 10h+c and the low limit is at 18h+c. Both are readable and writable. After reset the high limits hold 55h (85) and the low limits hold 00h. Writes to the status registers have no effect.
- R10: Flags change at the clock edge where `conv_valid` is sampled high. `alert_n` follows one edge later. `reg_rdata` is valid from the edge that samples `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | One-cycle strobe: a new set of readings is present |
| conv_temp | input | 32 | Readings, channel c in bits 8c+7:8c, signed |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; clears a status register when it is addressed |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| alert_n | output | 1 | Active-low alert |

## Verification
The hardest case to reach is a clearing read of a status register that lands on the same clock edge as a conversion that sets a new flag. The bench drives both strobes from a single task on the same falling edge. It then checks that the read data holds the pre-clear value and that a second read still sees the new flag. The consecutive-count gating of the alert is also difficult to reach, because a read can clear the flags while a channel's run is still counting. The bench reaches this case with runs of conversions, a read in the middle of a run, and an in-limit conversion that breaks a run.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_GSTAT = 8'h02;
  localparam logic [AW-1:0] A_CFG   = 8'h03;
  localparam logic [AW-1:0] A_HSTAT = 8'h35;
  localparam logic [AW-1:0] A_LSTAT = 8'h36;
  localparam logic [AW-1:0] A_HLIM  = 8'h10;
  localparam logic [AW-1:0] A_LLIM  = 8'h18;
  localparam logic [7:0]    HLIM_RST = 8'h55;
  localparam logic [7:0]    LLIM_RST = 8'h00;
endpackage

// File: rtl/tlm_chan.sv
module tlm_chan #(
  parameter int TW    = 8,
  parameter int CNT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 conv_valid,
  input  logic signed [TW-1:0] temp,
  input  logic signed [TW-1:0] hi_lim,
  input  logic signed [TW-1:0] lo_lim,
  input  logic                 cmp_mode,
  input  logic                 clr_hi,
  input  logic                 clr_lo,
  input  logic [CNT_W-1:0]     cnt_n,
  output logic                 hi_flag,
  output logic                 lo_flag,
  output logic                 qual
);
  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] run_cnt;
  logic hi_trip, lo_trip;

  assign hi_trip = temp > hi_lim;
  assign lo_trip = temp < lo_lim;
  assign qual    = run_cnt > {1'b0, cnt_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      hi_flag <= 1'b0;
      lo_flag <= 1'b0;
    end else begin
      if (conv_valid) begin
        if (hi_trip || lo_trip)
          run_cnt <= (run_cnt == CMAX) ? run_cnt : run_cnt + 1'b1;
        else
          run_cnt <= '0;
      end
      if (cmp_mode) begin
        if (conv_valid) begin
          hi_flag <= hi_trip;
          lo_flag <= lo_trip;
        end
      end else begin
        hi_flag <= (hi_flag & ~clr_hi) | (conv_valid & hi_trip);
        lo_flag <= (lo_flag & ~clr_lo) | (conv_valid & lo_trip);
      end
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    conv_valid && hi_trip |=> hi_flag); // R6
  AST_STICKY_HI: assert property (@(posedge clk) disable iff (rst)
    !cmp_mode && hi_flag && !clr_hi |=> hi_flag); // R4
  AST_RUN_BREAK: assert property (@(posedge clk) disable iff (rst)
    conv_valid && !hi_trip && !lo_trip |=> !qual); // R8
endmodule

// File: rtl/tlm_regs.sv
module tlm_regs
  import tlm_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int TW    = 8,
  parameter int CNT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [TW-1:0]           wdata,
  output logic [NCH-1:0][TW-1:0]  hi_lim,
  output logic [NCH-1:0][TW-1:0]  lo_lim,
  output logic                    cmp_mode,
  output logic [CNT_W-1:0]        cnt_n
);
  for (genvar c = 0; c < NCH; c++) begin : g_lim
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_lim[c] <= TW'(HLIM_RST);
        lo_lim[c] <= TW'(LLIM_RST);
      end else if (wr) begin
        if (addr == A_HLIM + AW'(c)) hi_lim[c] <= wdata;
        if (addr == A_LLIM + AW'(c)) lo_lim[c] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_mode <= 1'b0;
      cnt_n    <= '0;
    end else if (wr && addr == A_CFG) begin
      cmp_mode <= wdata[0];
      cnt_n    <= wdata[CNT_W:1];
    end
  end
endmodule

// File: rtl/thermal_limit_status.sv
module thermal_limit_status
  import tlm_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int TW    = 8,
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  input  logic [NCH*TW-1:0] conv_temp,
  input  logic [7:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [TW-1:0]     reg_wdata,
  output logic [TW-1:0]     reg_rdata,
  output logic              alert_n
);
  logic [NCH-1:0][TW-1:0] hi_lim, lo_lim;
  logic                   cmp_mode;
  logic [CNT_W-1:0]       cnt_n;
  logic [NCH-1:0]         hi_vec, lo_vec, qual_vec;
  logic                   clr_hi, clr_lo;
  logic [TW-1:0]          rd_mux;

  tlm_regs #(.NCH(NCH), .TW(TW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .cmp_mode(cmp_mode), .cnt_n(cnt_n)
  );

  assign clr_hi = reg_rd && (reg_addr == A_HSTAT);
  assign clr_lo = reg_rd && (reg_addr == A_LSTAT);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tlm_chan #(.TW(TW), .CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .conv_valid(conv_valid),
      .temp(conv_temp[c*TW +: TW]), .hi_lim(hi_lim[c]), .lo_lim(lo_lim[c]),
      .cmp_mode(cmp_mode), .clr_hi(clr_hi), .clr_lo(clr_lo), .cnt_n(cnt_n),
      .hi_flag(hi_vec[c]), .lo_flag(lo_vec[c]), .qual(qual_vec[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      A_HSTAT: rd_mux[NCH-1:0] = hi_vec;
      A_LSTAT: rd_mux[NCH-1:0] = lo_vec;
      A_GSTAT: rd_mux[1:0]     = {|hi_vec, |lo_vec};
      A_CFG:   rd_mux[CNT_W:0] = {cnt_n, cmp_mode};
      default: begin
        for (int c = 0; c < NCH; c++) begin
          if (reg_addr == A_HLIM + AW'(c)) rd_mux = hi_lim[c];
          if (reg_addr == A_LLIM + AW'(c)) rd_mux = lo_lim[c];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      alert_n   <= 1'b1;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      alert_n <= ~|(qual_vec & (hi_vec | lo_vec));
    end
  end

  AST_HI_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr_hi && !cmp_mode && !conv_valid |=> hi_vec == '0); // R4
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == A_HSTAT |=> reg_rdata[TW-1:NCH] == '0); // R2
  AST_ALERT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !alert_n |-> $past(|(hi_vec | lo_vec))); // R8
  AST_CMP_KEEPS: assert property (@(posedge clk) disable iff (rst)
    cmp_mode && !conv_valid |=> $stable(hi_vec)); // R7
endmodule

// File: tb/sim_thermal_limit_status.sv
module sim_thermal_limit_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_valid = 1'b0;
  logic [31:0] conv_temp = '0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic alert_n;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  thermal_limit_status u0 (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_temp(conv_temp),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alert_n(alert_n)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic conv(input logic [7:0] t0, t1, t2, t3);
    @(negedge clk); conv_temp = {t3, t2, t1, t0}; conv_valid = 1'b1;
    @(negedge clk); conv_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_all();
    logic [7:0] d;
    conv(8'd20, 8'd20, 8'd20, 8'd20);
    rd(8'h35, d); rd(8'h36, d);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h35, d); chk("R1 hstat", d, 8'h00);
    rd(8'h36, d); chk("R1 lstat", d, 8'h00);
    rd(8'h02, d); chk("R1 gstat", d, 8'h00);
    chk("R1 alert_n", {7'd0, alert_n}, 8'h01);
    rd(8'h13, d); chk("R9 hlim reset", d, 8'h55);
    rd(8'h18, d); chk("R9 llim reset", d, 8'h00);
    wr(8'h12, 8'd30); rd(8'h12, d); chk("R9 hlim write", d, 8'd30);
    wr(8'h18, 8'hF6); wr(8'h1B, 8'd10);
    rd(8'h18, d); chk("R9 llim write", d, 8'hF6);
  endtask

  task automatic t_high();
    logic [7:0] d;
    conv(8'd20, 8'd20, 8'd30, 8'd20);
    rd(8'h35, d); chk("R2 equal no trip", d, 8'h00);
    conv(8'd20, 8'd20, 8'd31, 8'd20);
    rd(8'h35, d); chk("R2 ch2 bit", d, 8'h04);
    rd(8'h35, d); chk("R4 read cleared", d, 8'h00);
    conv(8'd20, 8'd20, 8'd20, 8'h80);
    rd(8'h35, d); chk("R2 signed -128 no trip", d, 8'h00);
    clear_all();
  endtask

  task automatic t_low();
    logic [7:0] d;
    conv(8'hF6, 8'd20, 8'd20, 8'd20);
    rd(8'h36, d); chk("R3 equal no trip", d, 8'h00);
    conv(8'hF5, 8'd20, 8'd20, 8'd5);
    rd(8'h36, d); chk("R3 ch0 ch3 bits", d, 8'h09);
    rd(8'h36, d); chk("R3 cleared", d, 8'h00);
    clear_all();
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    conv(8'd20, 8'd100, 8'd20, 8'd20);
    conv(8'd20, 8'd20, 8'd20, 8'd20);
    rd(8'h02, d); chk("R5 summary high", d, 8'h02);
    rd(8'h02, d); chk("R5 gstat read no clear", d, 8'h02);
    rd(8'h35, d); chk("R4 sticky after in-limit", d, 8'h02);
    rd(8'h02, d); chk("R5 summary cleared", d, 8'h00);
    conv(8'd20, 8'd20, 8'd20, 8'd0);
    rd(8'h02, d); chk("R5 summary low", d, 8'h01);
    clear_all();
  endtask

  task automatic t_setwins();
    logic [7:0] d;
    @(negedge clk);
    reg_addr = 8'h35; reg_rd = 1'b1;
    conv_temp = {8'd20, 8'd50, 8'd20, 8'd20}; conv_valid = 1'b1;
    @(negedge clk); reg_rd = 1'b0; conv_valid = 1'b0; d = reg_rdata;
    chk("R6 old value returned", d, 8'h00);
    rd(8'h35, d); chk("R6 set kept", d, 8'h04);
    clear_all();
  endtask

  task automatic t_nowrite();
    logic [7:0] d;
    wr(8'h35, 8'hFF); wr(8'h36, 8'hFF);
    rd(8'h35, d); chk("R9 hstat not writable", d, 8'h00);
    rd(8'h36, d); chk("R9 lstat not writable", d, 8'h00);
  endtask

  task automatic t_comparator();
    logic [7:0] d;
    wr(8'h03, 8'h01);
    conv(8'd90, 8'd20, 8'd20, 8'd20);
    rd(8'h35, d); chk("R7 follows trip", d, 8'h01);
    rd(8'h35, d); chk("R7 read no clear", d, 8'h01);
    conv(8'd20, 8'd20, 8'd20, 8'd20);
    rd(8'h35, d); chk("R7 follows in-limit", d, 8'h00);
    wr(8'h03, 8'h00);
    clear_all();
  endtask

  task automatic t_alert();
    logic [7:0] d;
    wr(8'h03, 8'h04);
    clear_all();
    conv(8'd20, 8'd100, 8'd20, 8'd20);
    chk("R8 run 1 of 3", {7'd0, alert_n}, 8'h01);
    conv(8'd20, 8'd100, 8'd20, 8'd20);
    chk("R8 run 2 of 3", {7'd0, alert_n}, 8'h01);
    conv(8'd20, 8'd100, 8'd20, 8'd20);
    chk("R8 run 3 asserts (R10)", {7'd0, alert_n}, 8'h00);
    rd(8'h35, d); @(negedge clk);
    chk("R8 cleared flags release", {7'd0, alert_n}, 8'h01);
    conv(8'd20, 8'd100, 8'd20, 8'd20);
    chk("R8 run continues", {7'd0, alert_n}, 8'h00);
    conv(8'd20, 8'd20, 8'd20, 8'd20);
    chk("R8 in-limit breaks run", {7'd0, alert_n}, 8'h01);
    conv(8'd20, 8'd20, 8'd20, 8'd0);
    conv(8'd20, 8'd20, 8'd20, 8'd0);
    chk("R8 new run 2 of 3", {7'd0, alert_n}, 8'h01);
    conv(8'd20, 8'd20, 8'd20, 8'd0);
    chk("R8 low run asserts", {7'd0, alert_n}, 8'h00);
    wr(8'h03, 8'h00);
    clear_all();
    chk("R8 idle", {7'd0, alert_n}, 8'h01);
    conv(8'd20, 8'd100, 8'd20, 8'd20);
    chk("R8 N=0 single", {7'd0, alert_n}, 8'h00);
    clear_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_high();
    t_low();
    t_sticky();
    t_setwins();
    t_nowrite();
    t_comparator();
    t_alert();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule